// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block turns a fast reference clock into the 16x oversampling tick stream that a UART receiver and transmitter consume. Each serial bit is split into sixteen sub-bit tick periods. An integer divider value sets the base length of every tick period, and a 16-bit slot mask adds one extra reference clock to selected tick periods. Software spreads the extra clocks evenly across the bit by choosing a mask whose population count equals the fractional remainder. Fractional baud rates then come out without a phase accumulator. Good examples are 0x0808 for two extra clocks and 0x4924 for five.

The divider and the mask are shadowed in active registers. A change on the inputs is taken at the next bit boundary, so the bit in progress finishes with its old timing. A load strobe takes the inputs at once and restarts the bit at slot 0. When the enable input is low, the generator idles with its counters at zero.

The control is a two-state machine. In `ST_IDLE` (enable low) no ticks are produced and the counters are held at zero. The `IDLE_TO_RUN` transition is taken on the first clock edge that samples enable high, and that edge also captures divider and mask. In `ST_RUN` the period counter and slot sequencer advance. The `RUN_TO_IDLE` transition is taken on any edge that samples enable low.

Top module: `fbt_baud_gen`

## Requirements
- R1: After reset, `tick` and `bit_end` are low, and they stay low while `en` is low.
- R2: Tick period i of a bit (i = 0 is the first tick after a bit boundary or restart) lasts `div_val + 1` reference clocks when mask bit i is 0, and `div_val + 2` clocks when it is 1. Each `tick` pulse is one clock wide.
- R3: One bit period (16 ticks) lasts 16 × (`div_val` + 1) + popcount(`slot_mask`) reference clocks, for every remainder pattern 0..15.
- R4: `bit_end` is high together with every 16th tick after a restart, and never at any other time.
- R5: A change on `div_val` or `slot_mask` without `load` leaves the bit in progress unchanged and takes effect from slot 0 of the next bit.
- R6: A `load` sampled at a clock edge captures `div_val` and `slot_mask` and restarts at slot 0. The first tick follows slot 0's period length after that edge.
- R7: If `load` is sampled in the same cycle as the final count of a tick period, that tick (and its `bit_end`) is suppressed, and the restart of R6 applies.
- R8: An edge that samples `en` low returns the block to idle with no ticks. The edge that samples `en` high again captures the inputs, and the first tick follows slot 0's period length after it.
- R9: Within a bit, two adjacent tick periods differ by at most one reference clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the generator idle |
| div_val | input | DIV_W | Integer divider; base tick period is div_val + 1 clocks |
| slot_mask | input | SLOTS | Bit i stretches tick period i by one clock |
| load | input | 1 | Immediate capture of div_val/slot_mask and restart at slot 0 |
| tick | output | 1 | One-clock oversampling tick |
| bit_end | output | 1 | High with the 16th tick of each bit |

## Verification
A load strobe can land in the same cycle as a tick period's final count. The hardest case is the last count of slot 15, where a tick and the bit boundary would also fall due. The bench provokes this by counting clocks from the 15th tick of a bit and raising load exactly in the cycle before the 16th tick would appear. It judges the outcome by requiring that neither tick nor bit_end appears in the following cycle. It also requires that the next sixteen tick gaps follow the newly loaded divider and mask from slot 0.

// File: rtl/fbt_pkg.sv
package fbt_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fbt_state_e;
endpackage

// File: rtl/fbt_period_cnt.sv
module fbt_period_cnt #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [DIV_W-1:0] base,
    input  logic             stretch,
    output logic             last
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // final count of the period: base + stretch (length base + 1 + stretch)
    assign lim  = {1'b0, base} + {{DIV_W{1'b0}}, stretch};
    assign last = run && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || last) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fbt_slot_seq.sv
module fbt_slot_seq #(
    parameter int SLOTS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [SLOTS-1:0] mask,
    output logic             stretch,
    output logic             wrap
);
    localparam int IDX_W = $clog2(SLOTS);

    logic [IDX_W-1:0] idx;

    assign stretch = mask[idx];
    assign wrap    = (idx == IDX_W'(SLOTS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clr) begin
            idx <= '0;
        end else if (adv) begin
            idx <= wrap ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/fbt_baud_gen.sv
module fbt_baud_gen
    import fbt_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int SLOTS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_val,
    input  logic [SLOTS-1:0] slot_mask,
    input  logic             load,
    output logic             tick,
    output logic             bit_end
);
    fbt_state_e state, state_nxt;

    logic [DIV_W-1:0] act_div;
    logic [SLOTS-1:0] act_mask;
    logic             run, clr, done, fire, capture;
    logic             stretch, wrap;
    logic             tick_q, bend_q;

    assign run     = (state == ST_RUN) && en;
    assign clr     = load || !run;
    assign fire    = done && !load;
    assign capture = load || ((state == ST_IDLE) && en) || (fire && wrap);

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: state_nxt = en ? ST_RUN : ST_IDLE;   // IDLE_TO_RUN
            ST_RUN:  state_nxt = en ? ST_RUN : ST_IDLE;   // RUN_TO_IDLE
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // registered outputs and active configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q   <= 1'b0;
            bend_q   <= 1'b0;
            act_div  <= '0;
            act_mask <= '0;
        end else begin
            tick_q <= fire;
            bend_q <= fire && wrap;
            if (capture) begin
                act_div  <= div_val;
                act_mask <= slot_mask;
            end
        end
    end

    fbt_period_cnt #(.DIV_W(DIV_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .run     (run),
        .base    (act_div),
        .stretch (stretch),
        .last    (done)
    );

    fbt_slot_seq #(.SLOTS(SLOTS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .adv     (fire),
        .mask    (act_mask),
        .stretch (stretch),
        .wrap    (wrap)
    );

    assign tick    = tick_q;
    assign bit_end = bend_q;
endmodule

// File: rtl/fbt_baud_gen_chk.sv
module fbt_baud_gen_chk #(
    parameter int SLOTS = 16
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic load,
    input logic tick,
    input logic bit_end
);
    localparam int TC_W = $clog2(SLOTS) + 1;

    logic [TC_W-1:0] tcnt;

    // ticks seen since the last restart or bit boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
        end else if (load || !en) begin
            tcnt <= '0;
        end else if (tick) begin
            tcnt <= bit_end ? '0 : tcnt + 1'b1;
        end
    end

    a_r4_bitend_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |-> tick);

    a_r4_sixteenth_tick: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |-> (tcnt == TC_W'(SLOTS - 1)));

    a_r4_no_early_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !bit_end) |-> (tcnt != TC_W'(SLOTS - 1)));

    a_r7_load_silences: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!tick && !bit_end));

    a_r8_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick);
endmodule

bind fbt_baud_gen fbt_baud_gen_chk #(.SLOTS(SLOTS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .load    (load),
    .tick    (tick),
    .bit_end (bit_end)
);

// File: tb/tb_fbt_baud_gen.sv
`timescale 1ns/1ps
module tb_fbt_baud_gen;
    localparam int DIV_W = 8;
    localparam int SLOTS = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [DIV_W-1:0] div_val = '0;
    logic [SLOTS-1:0] slot_mask = '0;
    logic             load = 1'b0;
    logic             tick, bit_end;

    int nchk = 0;
    int nfail = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    fbt_baud_gen #(.DIV_W(DIV_W), .SLOTS(SLOTS)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .div_val(div_val),
        .slot_mask(slot_mask), .load(load), .tick(tick), .bit_end(bit_end)
    );

    function automatic logic [15:0] spread(input int n);
        case (n)
            0: spread = 16'h0000;  1: spread = 16'h0080;
            2: spread = 16'h0808;  3: spread = 16'h0888;
            4: spread = 16'h2222;  5: spread = 16'h4924;
            6: spread = 16'h4A52;  7: spread = 16'h54AA;
            8: spread = 16'h5555;  9: spread = 16'hD555;
            10: spread = 16'hD5D5; 11: spread = 16'hDDD5;
            12: spread = 16'hDDDD; 13: spread = 16'hDFDD;
            14: spread = 16'hDFDF; default: spread = 16'hFFDF;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // drive load for one edge; returns at the first negedge after capture
    task automatic load_cfg(input int d, input logic [15:0] m);
        @(negedge clk);
        div_val = DIV_W'(d);
        slot_mask = m;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    // starting at the first negedge after a restart edge, check n tick gaps
    task automatic expect_ticks(input int n, input int d0, input logic [15:0] m0,
                                input int d1, input logic [15:0] m1);
        int g = 0, j = 0, guard = 0, sum = 0, prevg = 0;
        while (1) begin
            if (!tick) begin
                if (bit_end) check(1'b0, "R4 bit_end without tick", 1, 0);
            end else begin
                int slot = j % 16;
                int d = (j < 16) ? d0 : d1;
                logic [15:0] m = (j < 16) ? m0 : m1;
                int expg = d + 1 + int'(m[slot]);
                check(g == expg, (j < 16) ? "R2 tick gap" : "R5 tick gap after boundary", g, expg);
                check(bit_end == (slot == 15), "R4 bit_end placement", int'(bit_end), int'(slot == 15));
                if (slot != 0)
                    check((g - prevg <= 1) && (prevg - g <= 1), "R9 adjacent gaps", g, prevg);
                sum += g;
                if (slot == 15) begin
                    check(sum == 16 * (d + 1) + $countones(m), "R3 bit length", sum, 16 * (d + 1) + $countones(m));
                    sum = 0;
                end
                prevg = g;
                g = 0;
                j++;
            end
            if (j >= n) break;
            @(negedge clk);
            g++;
            guard++;
            if (guard > 5000) begin
                check(1'b0, "R2 tick timeout", j, n);
                break;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        en = 1'b0;
        repeat (3) @(negedge clk);
        check(tick == 1'b0 && bit_end == 1'b0, "R1 reset outputs", int'({tick, bit_end}), 0);
        rst_n = 1'b1;
        repeat (10) begin
            @(negedge clk);
            check(tick == 1'b0 && bit_end == 1'b0, "R1 idle after reset", int'({tick, bit_end}), 0);
        end
    endtask

    task automatic t_sweep();
        en = 1'b1;
        for (int n = 0; n < 16; n++) begin
            load_cfg(3, spread(n));
            expect_ticks(16, 3, spread(n), 3, spread(n));
        end
        for (int n = 0; n < 16; n += 5) begin
            load_cfg(0, spread(n));
            expect_ticks(16, 0, spread(n), 0, spread(n));
            load_cfg(9, spread(15 - n));
            expect_ticks(16, 9, spread(15 - n), 9, spread(15 - n));
        end
    endtask

    task automatic t_boundary_update();
        load_cfg(2, 16'h0000);
        div_val = 8'd5;          // no load: must wait for the bit boundary
        slot_mask = 16'h5555;
        expect_ticks(32, 2, 16'h0000, 5, 16'h5555);
    endtask

    task automatic t_load_midbit();
        load_cfg(4, 16'h0808);
        expect_ticks(5, 4, 16'h0808, 4, 16'h0808);
        load_cfg(1, 16'h8001);   // R6 restart mid-bit
        expect_ticks(16, 1, 16'h8001, 1, 16'h8001);
    endtask

    task automatic t_load_collide();
        load_cfg(3, 16'h0000);
        expect_ticks(15, 3, 16'h0000, 3, 16'h0000);
        repeat (3) @(negedge clk);   // now in the final count cycle of slot 15
        div_val = 8'd2;
        slot_mask = 16'hFFFF;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check(tick == 1'b0 && bit_end == 1'b0, "R7 tick suppressed by load", int'({tick, bit_end}), 0);
        expect_ticks(16, 2, 16'hFFFF, 2, 16'hFFFF);
    endtask

    task automatic t_enable();
        load_cfg(2, 16'h0000);
        expect_ticks(3, 2, 16'h0000, 2, 16'h0000);
        @(negedge clk);
        en = 1'b0;
        div_val = 8'd6;
        slot_mask = 16'h0888;
        repeat (40) begin
            @(negedge clk);
            check(tick == 1'b0 && bit_end == 1'b0, "R8 no tick while disabled", int'({tick, bit_end}), 0);
        end
        en = 1'b1;
        @(negedge clk);
        expect_ticks(16, 6, 16'h0888, 6, 16'h0888);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_boundary_update();
        t_load_midbit();
        t_load_collide();
        t_enable();
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end
endmodule